// File: doc/BRIEF.md
# Clock Source Selector with Start-up Sequencer

This block turns a 4-bit source code into a choice among six incoming clock-enable streams. Each stream stands for an oscillator, a PLL output or an external clock, and all of them are pulses in one fabric clock domain. The block drives a single system clock enable for the core. It also holds the core stalled until the chosen source can be trusted.

After a reset, two intervals run in sequence. The first is a supply-settling interval counted on a low-frequency watchdog enable, 512 or 8192 pulses as chosen by a configuration input. The second is a source-stabilisation interval counted on the chosen source itself. A wake from power-down skips the watchdog interval and runs only the source interval.

One code value selects a compatibility mode. In that mode the system enable passes one pulse in four. A request for low-speed operation normally passes one pulse in `LS_DIV`, but it has no effect in compatibility mode. Codes that name no source raise a flag and leave the core stalled with no clock.

Top module: `clksel_top`

## Requirements
- R1: In RUN, with compatibility mode and low-speed request both inactive, `sys_clk_en` copies exactly one bit of `src_en` and ignores the other five. The code-to-bit mapping is: code 0000 → bit 0 (external), 0001 → bit 1 (PLL), 0010 and 0011 → bit 2 (internal RC), 0100 → bit 3 (128 kHz RC), 0110 → bit 4 (low-frequency crystal), and any code 1000–1111 → bit 5 (crystal/resonator).
- R2: Codes 0101 and 0111 drive `sel_reserved` high, hold `core_run` low and keep `sys_clk_en` low, whatever `src_en` does.
- R3: After `rst` falls, the sequencer waits for 512 `wdt_en` pulses when `long_tmo`=0, or 8192 when `long_tmo`=1. Source pulses that arrive during this wait are not counted.
- R4: After the watchdog wait, `core_run` rises on the cycle after the `SRC_DLY`-th (default 16) pulse of the selected source. `wdt_en` pulses during this phase have no effect.
- R5: `pd_req` in RUN drops `core_run` on the next cycle, and `sys_clk_en` stays low until wake. A `wake` pulse then starts only the source interval, and `core_run` returns after `SRC_DLY` selected pulses with no watchdog pulses needed.
- R6: Code 0011 selects compatibility mode. In that mode `sys_clk_en` passes the 1st, 5th, 9th and so on selected pulses after entry to RUN.
- R7: Outside compatibility mode, `low_speed_req`=1 makes `sys_clk_en` pass the 1st, (1+`LS_DIV`)-th and so on selected pulses after entry to RUN (default `LS_DIV`=8).
- R8: In compatibility mode, `low_speed_req` has no effect, and the one-in-four pattern of R6 stays.
- R9: `sys_clk_en` is never high while `core_run` is low.
- R10: While `rst` is high, `core_run` and `sys_clk_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the full start-up |
| sel_code | input | 4 | Clock source selection code |
| long_tmo | input | 1 | 1 selects the 8192-pulse watchdog interval, 0 the 512-pulse one |
| low_speed_req | input | 1 | Requests the reduced system enable rate |
| pd_req | input | 1 | Enter power-down from RUN |
| wake | input | 1 | Leave power-down |
| wdt_en | input | 1 | Watchdog oscillator enable pulse |
| src_en | input | 6 | Enable pulses of the six clock sources |
| sys_clk_en | output | 1 | System clock enable to the core |
| core_run | output | 1 | High when the core may execute |
| sel_reserved | output | 1 | Selection code names no source |

## Verification
The assertions assume that `sel_code` and `long_tmo` change only while `rst` is high, and that `wake` matters only in power-down. Under those assumptions, the divide counters and the phase transitions follow from a stable selection. The bench respects this by setting every code and timeout choice inside its reset task. Only `low_speed_req`, `pd_req`, `wake` and the enable streams move while the block runs.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int NUM_SRC = 6;

    typedef enum logic [2:0] {
        SRC_EXT    = 3'd0,
        SRC_PLL    = 3'd1,
        SRC_RCOSC  = 3'd2,
        SRC_LF128  = 3'd3,
        SRC_LFXTAL = 3'd4,
        SRC_HFXTAL = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        ST_RESET_DLY = 2'd0,
        ST_SRC_DLY   = 2'd1,
        ST_RUN       = 2'd2,
        ST_PDOWN     = 2'd3
    } seq_e;

    typedef struct packed {
        logic valid;
        logic compat;
        src_e src;
    } sel_t;

    function automatic sel_t decode_sel(input logic [3:0] code);
        sel_t r;
        r.valid  = 1'b1;
        r.compat = 1'b0;
        r.src    = SRC_EXT;
        casez (code)
            4'b0000: r.src = SRC_EXT;
            4'b0001: r.src = SRC_PLL;
            4'b0010: r.src = SRC_RCOSC;
            4'b0011: begin
                r.src    = SRC_RCOSC;
                r.compat = 1'b1;
            end
            4'b0100: r.src = SRC_LF128;
            4'b0110: r.src = SRC_LFXTAL;
            4'b1???: r.src = SRC_HFXTAL;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clksel_decode.sv
module clksel_decode
    import clksel_pkg::*;
(
    input  logic [3:0] code,
    output sel_t       sel,
    output logic       reserved
);

    always_comb begin
        sel      = decode_sel(code);
        reserved = ~sel.valid;
    end

endmodule

// File: rtl/clksel_mux.sv
module clksel_mux
    import clksel_pkg::*;
#(
    parameter int LS_DIV = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_en,
    input  sel_t               sel,
    input  logic               low_speed_req,
    input  logic               run,
    output logic               src_tick,
    output logic               sys_en
);

    localparam int DMAX = (LS_DIV > 4) ? LS_DIV : 4;
    localparam int DW   = $clog2(DMAX);

    logic [NUM_SRC-1:0] hit;
    logic [DW-1:0]      div_cnt;
    logic [DW-1:0]      div_lim;

    // one gate per source, only the decoded one may pass
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_en[g] & sel.valid & (sel.src == src_e'(g));
    end

    assign src_tick = |hit;

    // compatibility mode wins over the low-speed request
    always_comb begin
        if (sel.compat)
            div_lim = DW'(3);
        else if (low_speed_req)
            div_lim = DW'(LS_DIV - 1);
        else
            div_lim = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_cnt <= '0;
        else if (src_tick)
            div_cnt <= (div_cnt >= div_lim) ? '0 : div_cnt + 1'b1;
    end

    assign sys_en = run & src_tick & (div_cnt == '0);

    // R6
    compat_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (sel.compat && sys_en) |=> !sys_en);

    // R7
    ls_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel.compat && low_speed_req && sys_en) |=> !sys_en);

endmodule

// File: rtl/clksel_seq.sv
module clksel_seq
    import clksel_pkg::*;
#(
    parameter int SRC_DLY   = 16,
    parameter int WDT_SHORT = 512,
    parameter int WDT_LONG  = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic long_tmo,
    input  logic wdt_en,
    input  logic src_tick,
    input  logic pd_req,
    input  logic wake,
    output seq_e state
);

    localparam int CW = $clog2(WDT_LONG);
    localparam int SW = $clog2(SRC_DLY + 1);

    logic [CW-1:0] wcnt;
    logic [SW-1:0] scnt;
    logic [CW-1:0] wlim;

    assign wlim = long_tmo ? CW'(WDT_LONG - 1) : CW'(WDT_SHORT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET_DLY;
            wcnt  <= '0;
            scnt  <= '0;
        end else begin
            case (state)
                ST_RESET_DLY: begin
                    if (wdt_en) begin
                        if (wcnt == wlim) begin
                            state <= ST_SRC_DLY;
                            wcnt  <= '0;
                            scnt  <= '0;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                ST_SRC_DLY: begin
                    if (src_tick) begin
                        if (scnt == SW'(SRC_DLY - 1)) begin
                            state <= ST_RUN;
                            scnt  <= '0;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (pd_req) state <= ST_PDOWN;
                end
                ST_PDOWN: begin
                    if (wake) begin
                        state <= ST_SRC_DLY;
                        scnt  <= '0;
                    end
                end
                default: state <= ST_RESET_DLY;
            endcase
        end
    end

    // R3
    rst_to_src_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SRC_DLY && $past(state) == ST_RESET_DLY) |-> $past(wdt_en));

    // R4
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN)
            |-> ($past(state) == ST_SRC_DLY && $past(src_tick)));

    // R5
    wake_path_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SRC_DLY && $past(state) == ST_PDOWN) |-> $past(wake));

    // R5
    pdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PDOWN && !wake) |=> state == ST_PDOWN);

endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int SRC_DLY   = 16,
    parameter int LS_DIV    = 8,
    parameter int WDT_SHORT = 512,
    parameter int WDT_LONG  = 8192
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         sel_code,
    input  logic               long_tmo,
    input  logic               low_speed_req,
    input  logic               pd_req,
    input  logic               wake,
    input  logic               wdt_en,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               sys_clk_en,
    output logic               core_run,
    output logic               sel_reserved
);

    sel_t sel;
    seq_e state;
    logic src_tick;
    logic run;

    clksel_decode u_dec (
        .code     (sel_code),
        .sel      (sel),
        .reserved (sel_reserved)
    );

    clksel_seq #(
        .SRC_DLY   (SRC_DLY),
        .WDT_SHORT (WDT_SHORT),
        .WDT_LONG  (WDT_LONG)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .long_tmo (long_tmo),
        .wdt_en   (wdt_en),
        .src_tick (src_tick),
        .pd_req   (pd_req),
        .wake     (wake),
        .state    (state)
    );

    assign run      = (state == ST_RUN) & sel.valid;
    assign core_run = run;

    clksel_mux #(
        .LS_DIV (LS_DIV)
    ) u_mux (
        .clk           (clk),
        .rst           (rst),
        .src_en        (src_en),
        .sel           (sel),
        .low_speed_req (low_speed_req),
        .run           (run),
        .src_tick      (src_tick),
        .sys_en        (sys_clk_en)
    );

    // R2
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sel_reserved |-> (!core_run && !sys_clk_en));

    // R9
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        sys_clk_en |-> core_run);

    // R10
    always_comb begin
        if (rst && state == ST_RESET_DLY)
            rst_quiet_chk: assert (!core_run && !sys_clk_en);
    end

endmodule

// File: tb/sim_clksel_top.sv
`timescale 1ns/1ps
module sim_clksel_top;

    localparam int SDLY = 16;
    localparam int LSD  = 8;

    // {reserved, compat, source bit[2:0]} indexed by code
    localparam logic [4:0] VEC [16] = '{
        5'h00, 5'h01, 5'h02, 5'h0A, 5'h03, 5'h10, 5'h04, 5'h10,
        5'h05, 5'h05, 5'h05, 5'h05, 5'h05, 5'h05, 5'h05, 5'h05
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] sel_code = '0;
    logic       long_tmo = 1'b0;
    logic       low_speed_req = 1'b0;
    logic       pd_req = 1'b0;
    logic       wake = 1'b0;
    logic       wdt_en = 1'b0;
    logic [5:0] src_en = '0;
    logic       sys_clk_en, core_run, sel_reserved;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clksel_top u0 (
        .clk(clk), .rst(rst), .sel_code(sel_code), .long_tmo(long_tmo),
        .low_speed_req(low_speed_req), .pd_req(pd_req), .wake(wake),
        .wdt_en(wdt_en), .src_en(src_en), .sys_clk_en(sys_clk_en),
        .core_run(core_run), .sel_reserved(sel_reserved)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [3:0] code, input logic lng, input logic ls);
        rst = 1'b1;
        sel_code = code;
        long_tmo = lng;
        low_speed_req = ls;
        pd_req = 1'b0;
        wake = 1'b0;
        wdt_en = 1'b0;
        src_en = '1;
        repeat (3) tick();
        chk("R10 core_run", core_run, 1'b0);
        chk("R10 sys_clk_en", sys_clk_en, 1'b0);
        rst = 1'b0;
        src_en = '0;
    endtask

    task automatic pulses(input int n_wdt, input int n_src);
        wdt_en = 1'b1;
        src_en = '0;
        repeat (n_wdt) tick();
        wdt_en = 1'b0;
        src_en = '1;
        repeat (n_src) tick();
        src_en = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick();
        // table walk over all sixteen codes: R1, R2, R6
        for (int c = 0; c < 16; c++) begin
            logic [5:0] oh;
            do_reset(4'(c), 1'b0, 1'b0);
            pulses(512, SDLY);
            #1;
            oh = 6'(1) << VEC[c][2:0];
            if (VEC[c][4]) begin
                chk("R2 sel_reserved", sel_reserved, 1'b1);
                src_en = '1;
                #1;
                chk("R2 core_run", core_run, 1'b0);
                chk("R2 sys_clk_en", sys_clk_en, 1'b0);
            end else begin
                chk("R1 sel_reserved", sel_reserved, 1'b0);
                chk("R4 core_run", core_run, 1'b1);
                src_en = ~oh;
                #1;
                chk("R1 other sources", sys_clk_en, 1'b0);
                src_en = oh;
                #1;
                chk("R1 selected source", sys_clk_en, 1'b1);
                tick();
                if (VEC[c][3]) chk("R6 second pulse blocked", sys_clk_en, 1'b0);
                else           chk("R1 second pulse", sys_clk_en, 1'b1);
            end
            src_en = '0;
        end

        // R3 short interval boundary, then R4 source interval boundary
        do_reset(4'b0000, 1'b0, 1'b0);
        pulses(511, SDLY);
        chk("R3 511 watchdog pulses not enough", core_run, 1'b0);
        src_en = '1;
        #1;
        chk("R9 no enable while stalled", sys_clk_en, 1'b0);
        pulses(1, SDLY - 1);
        chk("R4 one source pulse short", core_run, 1'b0);
        pulses(0, 1);
        chk("R4 run after source interval", core_run, 1'b1);

        // R3 long interval boundary
        do_reset(4'b0001, 1'b1, 1'b0);
        pulses(8191, SDLY);
        chk("R3 8191 watchdog pulses not enough", core_run, 1'b0);
        pulses(1, SDLY - 1);
        chk("R4 long path one pulse short", core_run, 1'b0);
        wdt_en = 1'b1;
        repeat (5) tick();
        wdt_en = 1'b0;
        chk("R4 watchdog pulses ignored", core_run, 1'b0);
        pulses(0, 1);
        chk("R4 long path run", core_run, 1'b1);

        // R5 power-down and wake
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        chk("R5 power-down drops run", core_run, 1'b0);
        src_en = '1;
        #1;
        chk("R5 no enable in power-down", sys_clk_en, 1'b0);
        pulses(20, 4);
        chk("R5 stays down without wake", core_run, 1'b0);
        wake = 1'b1;
        tick();
        wake = 1'b0;
        pulses(0, SDLY - 1);
        chk("R5 wake one pulse short", core_run, 1'b0);
        pulses(0, 1);
        chk("R5 wake needs no watchdog", core_run, 1'b1);

        // R6 compatibility divide by four
        do_reset(4'b0011, 1'b0, 1'b0);
        pulses(512, SDLY);
        src_en = 6'b000100;
        for (int i = 0; i < 12; i++) begin
            #1;
            chk("R6 one in four", sys_clk_en, (i % 4) == 0);
            tick();
        end

        // R8 low-speed request ignored in compatibility mode
        do_reset(4'b0011, 1'b0, 1'b1);
        pulses(512, SDLY);
        src_en = 6'b000100;
        for (int i = 0; i < 12; i++) begin
            #1;
            chk("R8 still one in four", sys_clk_en, (i % 4) == 0);
            tick();
        end

        // R7 low-speed divide outside compatibility mode
        do_reset(4'b0010, 1'b0, 1'b1);
        pulses(512, SDLY);
        src_en = 6'b000100;
        for (int i = 0; i < 3 * LSD; i++) begin
            #1;
            chk("R7 one in LS_DIV", sys_clk_en, (i % LSD) == 0);
            tick();
        end
        src_en = '0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule